// File: doc/BRIEF.md
# Burst-of-Two Error-Corrected Synchronous Memory

This block is a synthesizable model of a synchronous memory with a shared data bus. The shared bus is split into a write-data input and a read-data output that has a valid flag. Each accepted command moves exactly two data beats. A command slot is two beat-clock cycles long. The first beat uses the word named by the command address. The second beat uses the word whose lowest index bit is inverted, so the two beats always land on the two words of one pair.

Write data arrives late, one and two cycles after the command. Each beat updates only the 9-bit lanes whose write enables are set. Every stored word carries single-error-correcting check bits. Read data leaves a fixed pipeline two command periods after the command.

If a word receives a write on some but not all of its lanes, the word is marked unprotected. Reads of a marked word return the stored bits unchanged. A later write that enables every lane re-encodes the word and clears the mark. A test port can flip any one stored bit, so the correction path can be exercised.

Top module: `ecc_b2_sram`

## Requirements
- R1: An accepted command addressed `a` moves two beats. Beat 0 uses word `a`. Beat 1 uses word `a` with bit 0 inverted.
- R2: A command is accepted when `cmd_vld` is high on a rising edge, unless the previous acceptance was on the edge just before. A strobe on that edge is ignored.
- R3: For a read accepted at edge E, `rd_q` shows beat 0 after edge E+4 and beat 1 after edge E+5. `rd_vld` is high in exactly those two cycles when no other read is pending.
- R4: For a write accepted at edge E, the data and enables for beat 0 are sampled at edge E+1. Those for beat 1 are sampled at edge E+2.
- R5: Enable bit i covers data bits 9i+8 down to 9i. Lanes whose enable is low keep their stored value. A beat with no enables leaves its word unchanged.
- R6: A read accepted two edges after a write to the same pair returns the newly written data.
- R7: In a protected word, a flip of any one of the 42 stored bits is corrected on read, and `rd_sec` is high for that beat. Injection bit indices 0 to 35 select data bits and 36 to 41 select check bits. `rd_sec` is low for an error-free beat.
- R8: After a write that enables some but not all lanes, reads of that word return the raw stored bits, including any flipped bit, with `rd_sec` low.
- R9: A later beat that enables all four lanes restores correction for that word.
- R10: While reset is asserted, `rd_vld` and `rd_sec` are low, and no word is marked unprotected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Beat clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_vld | input | 1 | Command strobe |
| cmd_wr | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | AW (4) | Word address of beat 0 |
| wr_en | input | LANES (4) | Per-lane write enables for the current beat |
| wr_d | input | 36 | Write data for the current beat |
| rd_q | output | 36 | Read data |
| rd_vld | output | 1 | Read data valid |
| rd_sec | output | 1 | Beat had a single error corrected |
| inj_en | input | 1 | Flip one stored bit on this edge |
| inj_addr | input | AW (4) | Word to corrupt |
| inj_bit | input | 6 | Bit index: 0 to 35 data, 36 to 41 check bits |

## Verification
The bench builds the block with its defaults: a 4-bit address (16 words), four 9-bit lanes, and a read latency of two command periods. This configuration keeps the whole array within reach. Every pair is written, and every word is read back starting from both the even and the odd word, so both burst orders are covered. All 42 stored-bit positions of one word are flipped in turn, to cover correction of every data bit and every check bit. Partial-lane writes, the disabled-correction path and its re-enable, a back-to-back write then read, and an ignored strobe in the second cycle of a slot are each checked at the exact cycle where the result must appear.

// File: rtl/ecc_b2_pkg.sv
package ecc_b2_pkg;

   // Smallest check width r with 2^r >= data + r + 1.
   function automatic int unsigned chk_width(input int unsigned dw);
      int unsigned r;
      r = 1;
      while ((1 << r) < dw + r + 1) r++;
      return r;
   endfunction

   // Codeword position (1-based) of data bit i: the i-th position that is not a power of two.
   function automatic int unsigned data_pos(input int unsigned i);
      int unsigned k;
      int unsigned res;
      k   = 0;
      res = 0;
      for (int unsigned p = 3; p < i + 64; p++) begin
         if ((p & (p - 1)) != 0) begin
            if (k == i && res == 0) res = p;
            k++;
         end
      end
      return res;
   endfunction

endpackage

// File: rtl/ecc_b2_codec.sv
module ecc_b2_codec #(
   parameter int unsigned DW = 36,
   parameter int unsigned CW = 6
) (
   input  logic [DW-1:0] enc_dat,
   output logic [CW-1:0] enc_chk,
   input  logic [DW-1:0] dec_dat,
   input  logic [CW-1:0] dec_chk,
   input  logic          dec_raw,
   output logic [DW-1:0] dec_out,
   output logic          dec_sec
);
   logic [CW-1:0] pos_tab [DW];
   logic [CW-1:0] syn;
   logic [DW-1:0] fix;

   for (genvar i = 0; i < DW; i++) begin : g_pos
      localparam int unsigned P = ecc_b2_pkg::data_pos(i);
      assign pos_tab[i] = CW'(P);
   end

   always_comb begin
      enc_chk = '0;
      for (int i = 0; i < DW; i++)
         for (int j = 0; j < CW; j++)
            if (pos_tab[i][j]) enc_chk[j] = enc_chk[j] ^ enc_dat[i];
   end

   always_comb begin
      syn = dec_chk;
      for (int i = 0; i < DW; i++)
         for (int j = 0; j < CW; j++)
            if (pos_tab[i][j]) syn[j] = syn[j] ^ dec_dat[i];
      for (int i = 0; i < DW; i++) fix[i] = (pos_tab[i] == syn);
   end

   always_comb begin
      if (dec_raw) begin
         dec_out = dec_dat;
         dec_sec = 1'b0;
      end else begin
         dec_out = dec_dat ^ fix;
         dec_sec = (syn != '0) && ((|fix) || $onehot(syn));
      end
   end
endmodule

// File: rtl/ecc_b2_array.sv
module ecc_b2_array #(
   parameter int unsigned IW = 4,
   parameter int unsigned DW = 36,
   parameter int unsigned CW = 6,
   parameter int unsigned BW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [IW-1:0] rd_idx,
   output logic [DW-1:0] rd_dat,
   output logic [CW-1:0] rd_chk,
   output logic          rd_raw,
   input  logic          wr_en,
   input  logic [IW-1:0] wr_idx,
   input  logic [DW-1:0] wr_dat,
   input  logic [CW-1:0] wr_chk,
   input  logic          wr_raw,
   input  logic          inj_en,
   input  logic [IW-1:0] inj_idx,
   input  logic [BW-1:0] inj_bit
);
   localparam int unsigned DEPTH = 1 << IW;
   localparam int unsigned NB    = DW + CW;

   logic [DW-1:0]    mem_d [DEPTH];
   logic [CW-1:0]    mem_c [DEPTH];
   logic [DEPTH-1:0] raw_q;
   logic [NB-1:0]    inj_mask;

   assign inj_mask = NB'(1) << inj_bit;
   assign rd_dat   = mem_d[rd_idx];
   assign rd_chk   = mem_c[rd_idx];
   assign rd_raw   = raw_q[rd_idx];

   always_ff @(posedge clk) begin
      if (wr_en) begin
         mem_d[wr_idx] <= wr_dat;
         mem_c[wr_idx] <= wr_chk;
      end else if (inj_en) begin
         mem_d[inj_idx] <= mem_d[inj_idx] ^ inj_mask[DW-1:0];
         mem_c[inj_idx] <= mem_c[inj_idx] ^ inj_mask[NB-1:DW];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     raw_q         <= '0;
      else if (wr_en) raw_q[wr_idx] <= wr_raw;
   end

   // R8, R9: the unprotected mark follows the kind of the last write to a word
   a_r9_flag_track: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> raw_q[$past(wr_idx)] == $past(wr_raw));
endmodule

// File: rtl/ecc_b2_sram.sv
module ecc_b2_sram #(
   parameter int unsigned AW     = 4,
   parameter int unsigned LANES  = 4,
   parameter int unsigned LANE_W = 9,
   parameter int unsigned RD_LAT = 2,
   localparam int unsigned DW    = LANES * LANE_W,
   localparam int unsigned CW    = ecc_b2_pkg::chk_width(DW),
   localparam int unsigned BW    = $clog2(DW + CW)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_vld,
   input  logic              cmd_wr,
   input  logic [AW-1:0]     cmd_addr,
   input  logic [LANES-1:0]  wr_en,
   input  logic [DW-1:0]     wr_d,
   output logic [DW-1:0]     rd_q,
   output logic              rd_vld,
   output logic              rd_sec,
   input  logic              inj_en,
   input  logic [AW-1:0]     inj_addr,
   input  logic [BW-1:0]     inj_bit
);
   localparam int unsigned LAT = 2 * RD_LAT;

   initial begin
      a_cfg_aw:  assert (AW >= 1);
      a_cfg_lat: assert (RD_LAT >= 1);
      a_cfg_ln:  assert (LANES >= 1 && LANE_W >= 1);
   end

   typedef struct packed {
      logic          vld;
      logic          sec;
      logic [DW-1:0] dat;
   } rd_beat_t;

   logic          cur_act, cur_beat, cur_wr;
   logic [AW-1:0] cur_addr;
   logic          acc;
   logic [AW-1:0] idx;
   logic [DW-1:0] arr_dat, dec_out, merged;
   logic [CW-1:0] arr_chk, enc_chk;
   logic          arr_raw, dec_sec;
   logic          wr_go;
   rd_beat_t      pipe [LAT];

   // slot control: a strobe in the second cycle of a slot is ignored
   assign acc = cmd_vld && !(cur_act && !cur_beat);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_act  <= 1'b0;
         cur_beat <= 1'b0;
         cur_wr   <= 1'b0;
         cur_addr <= '0;
      end else if (acc) begin
         cur_act  <= 1'b1;
         cur_beat <= 1'b0;
         cur_wr   <= cmd_wr;
         cur_addr <= cmd_addr;
      end else if (cur_act && !cur_beat) begin
         cur_beat <= 1'b1;
      end else begin
         cur_act  <= 1'b0;
      end
   end

   // beat counter preset from the low address bit, toggled for beat 1
   assign idx = cur_addr ^ AW'(cur_beat);

   ecc_b2_array #(.IW(AW), .DW(DW), .CW(CW), .BW(BW)) i_array (
      .clk(clk), .rst_n(rst_n),
      .rd_idx(idx), .rd_dat(arr_dat), .rd_chk(arr_chk), .rd_raw(arr_raw),
      .wr_en(wr_go), .wr_idx(idx), .wr_dat(merged), .wr_chk(enc_chk),
      .wr_raw(!(&wr_en)),
      .inj_en(inj_en), .inj_idx(inj_addr), .inj_bit(inj_bit)
   );

   ecc_b2_codec #(.DW(DW), .CW(CW)) i_codec (
      .enc_dat(merged), .enc_chk(enc_chk),
      .dec_dat(arr_dat), .dec_chk(arr_chk), .dec_raw(arr_raw),
      .dec_out(dec_out), .dec_sec(dec_sec)
   );

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign merged[l*LANE_W +: LANE_W] = wr_en[l] ? wr_d[l*LANE_W +: LANE_W]
                                                   : dec_out[l*LANE_W +: LANE_W];
   end

   assign wr_go = cur_act && cur_wr && (|wr_en);

   for (genvar s = 0; s < LAT; s++) begin : g_stage
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            pipe[s] <= '0;
         end else if (s == 0) begin
            pipe[s].vld <= cur_act && !cur_wr;
            pipe[s].sec <= cur_act && !cur_wr && dec_sec;
            pipe[s].dat <= dec_out;
         end else begin
            pipe[s] <= pipe[(s == 0) ? 0 : s - 1];
         end
      end
   end

   assign rd_q   = pipe[LAT-1].dat;
   assign rd_vld = pipe[LAT-1].vld;
   assign rd_sec = pipe[LAT-1].sec;

   // R1: acceptance opens beat 0 of a slot at the commanded address
   a_r1_slot_open: assert property (@(posedge clk) disable iff (!rst_n)
      acc |=> cur_act && !cur_beat && cur_addr == $past(cmd_addr));
   // R2: beat 0 is always followed by beat 1 of the same command
   a_r2_no_cut: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_act && !cur_beat) |=> cur_act && cur_beat && $stable(cur_addr));
   // R8: an unprotected word passes through the decoder untouched
   a_r8_raw_pass: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_act && arr_raw) |-> (dec_out == arr_dat) && !dec_sec);
   // R10: no output activity straight out of reset
   a_r10_quiet: assert property (@(posedge clk)
      !rst_n |=> !rd_vld && !rd_sec);
endmodule

// File: tb/test_ecc_b2_sram.sv
module test_ecc_b2_sram;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        cmd_vld, cmd_wr;
   logic [3:0]  cmd_addr;
   logic [3:0]  wr_en;
   logic [35:0] wr_d;
   logic [35:0] rd_q;
   logic        rd_vld, rd_sec;
   logic        inj_en;
   logic [3:0]  inj_addr;
   logic [5:0]  inj_bit;

   int n_run  = 0;
   int n_fail = 0;
   logic [35:0] mdl [16];

   always #5ns clk = ~clk;

   ecc_b2_sram i_ecc_b2_sram (
      .clk(clk), .rst_n(rst_n), .cmd_vld(cmd_vld), .cmd_wr(cmd_wr),
      .cmd_addr(cmd_addr), .wr_en(wr_en), .wr_d(wr_d), .rd_q(rd_q),
      .rd_vld(rd_vld), .rd_sec(rd_sec), .inj_en(inj_en),
      .inj_addr(inj_addr), .inj_bit(inj_bit)
   );

   task automatic chk(input bit ok, input string req, input logic [35:0] act, input logic [35:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [35:0] pat(input int i);
      return {4'(i * 7 + 3), (32'(i) * 32'h9E37_79B1) ^ 32'h5A5A_0F0F};
   endfunction

   function automatic logic [35:0] lmerge(input logic [35:0] old, input logic [35:0] nw, input logic [3:0] en);
      logic [35:0] r;
      r = old;
      for (int l = 0; l < 4; l++) if (en[l]) r[l*9 +: 9] = nw[l*9 +: 9];
      return r;
   endfunction

   task automatic wr(input logic [3:0] a, input logic [3:0] e0, input logic [35:0] d0,
                     input logic [3:0] e1, input logic [35:0] d1);
      @(negedge clk); cmd_vld = 1; cmd_wr = 1; cmd_addr = a;
      @(negedge clk); cmd_vld = 0; wr_en = e0; wr_d = d0;
      @(negedge clk); wr_en = e1; wr_d = d1;
      mdl[a]        = lmerge(mdl[a], d0, e0);
      mdl[a ^ 4'd1] = lmerge(mdl[a ^ 4'd1], d1, e1);
      @(negedge clk); wr_en = 0;
   endtask

   // done = number of negedges already passed since the accepting edge
   task automatic collect(input int done, output logic [35:0] q0, output logic [35:0] q1,
                          output logic s0, output logic s1);
      repeat (3 - done) @(negedge clk);
      @(negedge clk); chk(!rd_vld, "R3 no data before latency", 36'(rd_vld), 0);
      @(negedge clk); q0 = rd_q; s0 = rd_sec; chk(rd_vld, "R3 beat0 valid", 36'(rd_vld), 1);
      @(negedge clk); q1 = rd_q; s1 = rd_sec; chk(rd_vld, "R3 beat1 valid", 36'(rd_vld), 1);
      @(negedge clk); chk(!rd_vld, "R3 exactly two beats", 36'(rd_vld), 0);
   endtask

   task automatic rd(input logic [3:0] a, output logic [35:0] q0, output logic [35:0] q1,
                     output logic s0, output logic s1);
      @(negedge clk); cmd_vld = 1; cmd_wr = 0; cmd_addr = a;
      @(negedge clk); cmd_vld = 0;
      collect(1, q0, q1, s0, s1);
   endtask

   task automatic inject(input logic [3:0] a, input logic [5:0] b);
      @(negedge clk); inj_en = 1; inj_addr = a; inj_bit = b;
      @(negedge clk); inj_en = 0;
   endtask

   task automatic summary();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      logic [35:0] q0, q1, e;
      logic s0, s1;
      rst_n = 0; cmd_vld = 0; cmd_wr = 0; cmd_addr = 0; wr_en = 0; wr_d = 0;
      inj_en = 0; inj_addr = 0; inj_bit = 0;
      repeat (3) @(negedge clk);
      chk(!rd_vld && !rd_sec, "R10 reset outputs", {34'd0, rd_vld, rd_sec}, 0);
      rst_n = 1;

      // R1, R4: fill every pair, read back from both words of the pair
      for (int p = 0; p < 8; p++) wr(4'(2 * p), 4'hF, pat(2 * p), 4'hF, pat(2 * p + 1));
      for (int a = 0; a < 16; a++) begin
         rd(4'(a), q0, q1, s0, s1);
         chk(q0 === mdl[a], "R1 beat0 word", q0, mdl[a]);
         chk(q1 === mdl[a ^ 1], "R1 beat1 toggled word", q1, mdl[a ^ 1]);
         chk(!s0 && !s1, "R7 clean read no sec", {34'd0, s0, s1}, 0);
      end

      // R6: read accepted two edges after a write to the same pair
      @(negedge clk); cmd_vld = 1; cmd_wr = 1; cmd_addr = 4'd7;
      @(negedge clk); cmd_vld = 0; wr_en = 4'hF; wr_d = pat(70);
      @(negedge clk); wr_en = 4'hF; wr_d = pat(71); cmd_vld = 1; cmd_wr = 0; cmd_addr = 4'd7;
      mdl[7] = pat(70); mdl[6] = pat(71);
      @(negedge clk); cmd_vld = 0; wr_en = 0;
      collect(1, q0, q1, s0, s1);
      chk(q0 === mdl[7], "R6 coherent beat0", q0, mdl[7]);
      chk(q1 === mdl[6], "R6 coherent beat1", q1, mdl[6]);

      // R2: strobe held into the second slot cycle with another address is ignored
      @(negedge clk); cmd_vld = 1; cmd_wr = 0; cmd_addr = 4'd10;
      @(negedge clk); cmd_addr = 4'd12;
      @(negedge clk); cmd_vld = 0;
      collect(2, q0, q1, s0, s1);
      chk(q0 === mdl[10], "R2 ignored strobe beat0", q0, mdl[10]);
      chk(q1 === mdl[11], "R2 ignored strobe beat1", q1, mdl[11]);

      // R7: every stored bit position of word 4 corrected
      for (int b = 0; b < 42; b++) begin
         wr(4'd4, 4'hF, pat(100 + b), 4'hF, pat(200 + b));
         inject(4'd4, 6'(b));
         rd(4'd4, q0, q1, s0, s1);
         chk(q0 === mdl[4], "R7 corrected data", q0, mdl[4]);
         chk(s0 && !s1, "R7 sec flag on corrected beat only", {34'd0, s0, s1}, 36'd2);
      end

      // R5: partial lanes on beat0, no lanes on beat1
      wr(4'd8, 4'hF, pat(300), 4'hF, pat(301));
      wr(4'd8, 4'b0011, pat(302), 4'b0000, pat(303));
      rd(4'd8, q0, q1, s0, s1);
      e = {pat(300)[35:18], pat(302)[17:0]};
      chk(q0 === e, "R5 lane merge", q0, e);
      chk(q1 === pat(301), "R5 no-enable beat unchanged", q1, pat(301));

      // R8: partial-written word returns raw, fully written neighbour still corrected
      inject(4'd8, 6'd20);
      inject(4'd9, 6'd3);
      rd(4'd8, q0, q1, s0, s1);
      e = mdl[8] ^ (36'd1 << 20);
      chk(q0 === e, "R8 raw data after half write", q0, e);
      chk(!s0, "R8 no sec on raw word", 36'(s0), 0);
      chk(q1 === mdl[9] && s1, "R8 protected neighbour corrected", q1, mdl[9]);

      // R9: full write restores correction
      wr(4'd8, 4'hF, pat(310), 4'h0, 36'd0);
      inject(4'd8, 6'd20);
      rd(4'd8, q0, q1, s0, s1);
      chk(q0 === mdl[8], "R9 corrected after full write", q0, mdl[8]);
      chk(s0, "R9 sec raised again", 36'(s0), 1);

      summary();
   end
endmodule